// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Selector

This block picks one of two free-running clocks and drives it onto a single clock output. When the select line changes, the output is never allowed to show a shortened pulse. The clock in use completes its present high phase. The output then sits low while the old clock is shut off and the other clock is counted through a fixed settling window. Only after that window is the new clock passed through. The intended use is at the root of a clock tree where a runt pulse could corrupt downstream state.

The sequencing state machine runs on channel 0's clock. Channel 0 must therefore keep toggling until a switch has completed, in either direction. The clock being left behind must also keep running until the new clock reaches the output, or the switch stalls with the output held low. Each channel has its own gate. A gate brings its request into its own clock domain through a two-flop synchroniser, counts the settling cycles there, and changes its output enable only on a falling edge of its clock. The select line and the enable acknowledgements are likewise synchronised into the channel 0 domain.

Status pins are plain levels. `busy` is high while a switch is in progress. `done` is a single-cycle pulse in the channel 0 domain that marks completion.

Top module: `glitchfree_clkmux`

## Requirements
- R1: No high or low phase of `clk_out` is shorter than half the period of the faster input clock, including across switches.
- R2: On a switch, the high phase of the outgoing clock in progress finishes. `clk_out` then stays low, and the first rising edge after that low window coincides with a rising edge of the new clock.
- R3: The low window of a switch contains at least `WAIT_CYCLES` (default 5) rising edges of the new clock before the first rising edge of `clk_out`.
- R4: The two channel requests are never asserted together. A channel's enable rises only while its synchronised request is high, and never in the cycle directly after that request rises.
- R5: `busy` rises within four channel 0 cycles after `sel` differs from the active channel. It stays high until the new clock drives `clk_out`, and falls on the same channel 0 edge that raises `done`.
- R6: `done` is high for exactly one channel 0 cycle per completed switch.
- R7: A change of `sel` while `busy` is high does not alter the switch in progress. After `done`, the block acts on the value `sel` then holds: it starts a new switch if `sel` differs, and none if `sel` equals the new channel.
- R8: An asynchronous low `rst_n` selects channel 0 with its enable set, clears the settling counters, and forces `busy` and `done` low. After release, `clk_out` follows `clk0`.
- R9: Outside a switch, `clk_out` equals the active input clock (channel 0 when `sel`=0, channel 1 when `sel`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Clock channel 0; also clocks the sequencing state machine |
| clk1 | input | 1 | Clock channel 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Requested channel (0 or 1), asynchronous to both clocks |
| clk_out | output | 1 | Selected clock, free of runt pulses |
| busy | output | 1 | High while a switch is in progress |
| done | output | 1 | One-cycle pulse (channel 0 domain) when a switch completes |

## Verification
On every cycle, the assertions check that the two requests are mutually exclusive, that an enable rises only under its own request and never in the cycle right after it, that `done` lasts one cycle and ends `busy`, and that the active channel cannot change mid-switch. The properties that depend on real time need the bench. The bench measures the width of every output phase and counts new-clock edges inside each low window. It also checks that the window ends on a new-clock edge, that a select change during a switch is deferred, and that reset leaves the output on channel 0.

// File: rtl/gmux_pkg.sv
`timescale 1ns/100ps
package gmux_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DROP  = 2'd1,
    SW_RAISE = 2'd2
  } sw_state_e;
endpackage

// File: rtl/gmux_sync.sv
`timescale 1ns/100ps
module gmux_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gmux_chan.sv
`timescale 1ns/100ps
module gmux_chan #(
  parameter int unsigned WAIT     = 5,
  parameter bit          START_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en
);
  localparam int unsigned CW = $clog2(WAIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(WAIT);

  logic          req_s;
  logic [CW-1:0] cnt;
  logic          armed;

  gmux_sync #(.RST_VAL(START_ON)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req), .q(req_s)
  );

  // settle counter: counts own-clock rising edges while the request holds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!req_s)         cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // an enabled channel stays enabled while requested
  assign armed = req_s && (en || (cnt == CNT_MAX));

  // enable moves only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= START_ON;
    else        en <= armed;
  end

  // R4: enable rises only under a live request
  p_en_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> req_s);

  // R4/R3: a fresh request never enables the channel in the very next cycle
  p_no_early_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_s) |=> !en);
endmodule

// File: rtl/gmux_ctrl.sv
`timescale 1ns/100ps
module gmux_ctrl
  import gmux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [1:0] en_ack,
  output logic [1:0] req,
  output logic       busy,
  output logic       done
);
  logic       sel_s;
  logic [1:0] ack_s;
  logic       cur;
  sw_state_e  state;

  gmux_sync #(.RST_VAL(1'b0)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d(sel), .q(sel_s)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_ack
    gmux_sync #(.RST_VAL(gi == 0)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(en_ack[gi]), .q(ack_s[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SW_IDLE;
      cur   <= 1'b0;
      req   <= 2'b01;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SW_IDLE: if (sel_s != cur) begin
          req[cur] <= 1'b0;
          busy     <= 1'b1;
          state    <= SW_DROP;
        end
        SW_DROP: if (!ack_s[cur]) begin
          req[~cur] <= 1'b1;
          state     <= SW_RAISE;
        end
        SW_RAISE: if (ack_s[~cur]) begin
          cur   <= ~cur;
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= SW_IDLE;
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  // R4: never request both channels
  p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req[0] && req[1]));

  // R6: completion pulse lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: done closes a busy period
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7: active channel frozen during a switch
  p_hold_cur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable(cur)));
endmodule

// File: rtl/glitchfree_clkmux.sv
`timescale 1ns/100ps
module glitchfree_clkmux #(
  parameter int unsigned WAIT_CYCLES = 5
) (
  input  logic clk0,
  input  logic clk1,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out,
  output logic busy,
  output logic done
);
  logic [1:0] clk_in;
  logic [1:0] req;
  logic [1:0] en;

  assign clk_in = {clk1, clk0};

  gmux_ctrl u_ctrl (
    .clk(clk0), .rst_n(rst_n), .sel(sel), .en_ack(en),
    .req(req), .busy(busy), .done(done)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_ch
    gmux_chan #(.WAIT(WAIT_CYCLES), .START_ON(gi == 0)) u_ch (
      .clk(clk_in[gi]), .rst_n(rst_n), .req(req[gi]), .en(en[gi])
    );
  end

  assign clk_out = |(clk_in & en);
endmodule

// File: tb/test_glitchfree_clkmux.sv
`timescale 1ns/100ps
module test_glitchfree_clkmux;
  localparam realtime P0 = 10.0;
  localparam realtime P1 = 7.0;
  localparam int      WAIT_CYCLES = 5;
  localparam realtime MIN_PHASE = P1 / 2.0 - 0.05;
  localparam realtime LONG_LOW = P0;

  logic clk0 = 1'b0, clk1 = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic clk_out, busy, done;

  int checks = 0, errors = 0;

  glitchfree_clkmux #(.WAIT_CYCLES(WAIT_CYCLES)) i_glitchfree_clkmux (
    .clk0(clk0), .clk1(clk1), .rst_n(rst_n), .sel(sel),
    .clk_out(clk_out), .busy(busy), .done(done)
  );

  always #(P0 / 2.0) clk0 = ~clk0;
  always #(P1 / 2.0) clk1 = ~clk1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $realtime);
    end
  endtask

  // behavioural model state
  logic    src = 1'b0;
  bit      mon_en = 1'b0;
  bit      started = 1'b0;
  realtime t_fall = 0.0, t_rise = 0.0;
  int      n_edge0 = 0, n_edge1 = 0;
  realtime last0 = -1.0, last1 = -1.0;
  int      done_count = 0;
  logic    prev_busy = 1'b0, prev_done = 1'b0;

  always @(posedge clk0) begin n_edge0++; last0 = $realtime; end
  always @(posedge clk1) begin n_edge1++; last1 = $realtime; end

  always @(negedge clk_out) begin
    if (mon_en && started)
      check(($realtime - t_rise) >= MIN_PHASE, "R1", "high phase x10ns",
            int'(($realtime - t_rise) * 10), int'(MIN_PHASE * 10));
    t_fall  = $realtime;
    n_edge0 = 0;
    n_edge1 = 0;
    started = 1'b1;
  end

  always @(posedge clk_out) begin
    realtime low;
    int      n;
    logic    tgt;
    low = $realtime - t_fall;
    t_rise = $realtime;
    if (mon_en && started) begin
      check(low >= MIN_PHASE, "R1", "low phase x10ns", int'(low * 10), int'(MIN_PHASE * 10));
      if (low > LONG_LOW) begin
        tgt = ~src;
        n = tgt ? (n_edge1 - ((last1 == $realtime) ? 1 : 0))
                : (n_edge0 - ((last0 == $realtime) ? 1 : 0));
        check(n >= WAIT_CYCLES, "R3", "new-clock edges in low window", n, WAIT_CYCLES);
        #0.5;
        check((tgt ? clk1 : clk0) == 1'b1, "R2", "window ends on new clock high",
              int'(tgt ? clk1 : clk0), 1);
      end
    end
  end

  // model update of the active source on done
  always @(posedge clk0) begin
    #0.5;
    if (!rst_n) src = 1'b0;
    else if (done) src = ~src;
  end

  // steady-state comparison every clock
  always @(posedge clk0) begin
    #1;
    if (mon_en && !busy && src == 1'b0)
      check(clk_out == 1'b1, "R9", "clk_out high with clk0", int'(clk_out), 1);
  end
  always @(negedge clk0) begin
    #1;
    if (mon_en && !busy && src == 1'b0)
      check(clk_out == 1'b0, "R9", "clk_out low with clk0", int'(clk_out), 0);
  end
  always @(posedge clk1) begin
    #1;
    if (mon_en && !busy && src == 1'b1)
      check(clk_out == 1'b1, "R9", "clk_out high with clk1", int'(clk_out), 1);
  end
  always @(negedge clk1) begin
    #1;
    if (mon_en && !busy && src == 1'b1)
      check(clk_out == 1'b0, "R9", "clk_out low with clk1", int'(clk_out), 0);
  end

  // status sampling in the channel 0 domain
  always @(negedge clk0) begin
    if (rst_n) begin
      if (done) begin
        done_count++;
        check(prev_busy && !busy, "R5", "busy falls with done", int'(busy), 0);
        check(!prev_done, "R6", "done pulse width", 2, 1);
      end
    end
    prev_busy = busy;
    prev_done = done;
  end

  task automatic wait_busy(input string req);
    int k;
    k = 0;
    while (!busy && k < 10) begin @(negedge clk0); k++; end
    check(busy && k <= 4, req, "cycles until busy", k, 4);
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (k < 200) begin
      @(negedge clk0);
      if (done) break;
      k++;
    end
    check(k < 200, req, "switch completes", k, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk0);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dc;
    #13;
    check(busy == 1'b0 && done == 1'b0, "R8", "status in reset", int'({busy, done}), 0);
    @(negedge clk0);
    rst_n = 1'b1;
    idle(3);
    mon_en = 1'b1;
    idle(10);

    // switch 0 -> 1
    sel = 1'b1;
    wait_busy("R5");
    wait_done("R5");
    idle(2);
    check(src == 1'b1, "R9", "model on channel 1", int'(src), 1);
    idle(15);

    // switch 1 -> 0
    sel = 1'b0;
    wait_busy("R5");
    wait_done("R5");
    idle(15);

    // R7: reversal during a switch is deferred, then acted on
    dc = done_count;
    sel = 1'b1;
    wait_busy("R7");
    idle(2);
    sel = 1'b0;
    wait_done("R7");
    idle(1);
    wait_busy("R7");
    wait_done("R7");
    idle(5);
    check(done_count - dc == 2, "R7", "switches after reversal", done_count - dc, 2);
    check(src == 1'b0 && !busy, "R7", "ends on channel 0", int'(src), 0);

    // R7: glitch on sel during a switch leaves no second switch
    dc = done_count;
    sel = 1'b1;
    wait_busy("R7");
    sel = 1'b0;
    idle(2);
    sel = 1'b1;
    wait_done("R7");
    idle(12);
    check(!busy && done_count - dc == 1, "R7", "no extra switch", done_count - dc, 1);
    check(src == 1'b1, "R7", "stays on channel 1", int'(src), 1);

    // R8: asynchronous reset while on channel 1
    mon_en = 1'b0;
    #2.3;
    rst_n = 1'b0;
    sel = 1'b0;
    #1;
    check(!busy && !done, "R8", "status forced low", int'({busy, done}), 0);
    idle(2);
    rst_n = 1'b1;
    idle(3);
    check(src == 1'b0, "R8", "model back on channel 0", int'(src), 0);
    @(posedge clk0); #1;
    check(clk_out == 1'b1, "R8", "clk_out follows clk0 high", int'(clk_out), 1);
    @(negedge clk0); #1;
    check(clk_out == 1'b0, "R8", "clk_out follows clk0 low", int'(clk_out), 0);
    started = 1'b0;
    mon_en = 1'b1;
    idle(10);
    check(!busy, "R8", "no switch after reset", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule